// File: doc/BRIEF.md
# SD Programmed-I/O Data Buffer

This block is the halfword staging buffer between a host register port and the card data path of an SD host controller. Software moves data 16 bits at a time through a single data register. On the card side the serial line engine is abstracted as two valid/ready halfword streams, one into the buffer for card-to-host traffic and one out of it for host-to-card traffic. A transfer is armed by a start pulse that records the direction and the length, given as a block length in bytes times a block count.

Occupancy flags tell software how much it may move per service. One flag says that two halfwords (one 4-byte word) can be read. A second says that sixteen halfwords (a 32-byte burst) can be read. A third says that two halfwords can be written. Empty, full, receive-active and transmit-active flags, a completion flag and a sticky underflow bit complete the status.

Card-side streams follow valid/ready rules. A beat moves on a cycle where valid and ready are both high. The buffer may drop `card_rx_ready` at any time it is full or has no halfwords left to take. While `card_tx_valid` is high and the card holds `card_tx_ready` low, the buffer keeps `card_tx_valid` high and `card_tx_data` unchanged until a start pulse.

Top module: `sd_data_port`

## Requirements
- R1: After reset the buffer is empty. `fifo_empty` and `wr_ready_small` are 1. `fifo_full`, both read-ready flags, `rx_active`, `tx_active`, `data_done` and `rd_underflow` are 0. `host_rd_data` is 0, and the direction is host-to-card.
- R2: A `xfer_start` pulse does the following:
  - It records the direction (`xfer_dir_rx` = 1 means card-to-host).
  - It loads the halfword count ceil(`blk_bytes` × `blk_num` / 2).
  - It empties the buffer and clears `rd_underflow`.
  - Host and card traffic presented in that same cycle is discarded.
- R3: Halfwords leave in the order they entered, and the buffer holds 32 of them. In every data word, byte 0 of the pair sits in bits 7:0 and byte 1 in bits 15:8, and the two bytes are never swapped.
- R4: `rd_ready_small` is 1 exactly when the buffer holds at least 2 halfwords.
- R5: `rd_ready_burst` is 1 exactly when the buffer holds at least 16 halfwords.
- R6: `wr_ready_small` is 1 exactly when at least 2 halfword slots are free.
- R7: `fifo_empty` is 1 exactly at 0 halfwords held, and `fifo_full` is 1 exactly at 32.
- R8: The host data write has these rules:
  - In host-to-card mode, a write stores one halfword.
  - A write while the buffer is full is dropped.
  - In card-to-host mode, host writes are ignored.
- R9: The host data read has these rules:
  - A read in card-to-host mode while the buffer is empty leaves `host_rd_data` at its last value and sets `rd_underflow`, which stays set until the next start.
  - In host-to-card mode, host reads are ignored.
- R10: `card_rx_ready` is 1 only in card-to-host mode, while halfwords remain to be received and the buffer is not full. Each accepted beat counts one halfword off the remaining count. `rx_active` is 1 while the mode is card-to-host and the count is non-zero.
- R11: `card_tx_valid` is 1 only in host-to-card mode, while halfwords remain and the buffer is not empty. `card_tx_data` is the oldest halfword, and it is held stable under back-pressure. `tx_active` is 1 while the mode is host-to-card and the count is non-zero.
- R12: `data_done` is 1 once a start has been seen, the remaining count is zero and the buffer is empty. It stays 1 until the next start, and a zero-length transfer completes at once.
- R13: In card-to-host mode, a host read of a non-empty buffer removes the oldest halfword. That halfword appears on `host_rd_data` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Arm a transfer, flush the buffer |
| xfer_dir_rx | input | 1 | Direction at start: 1 card-to-host, 0 host-to-card |
| blk_bytes | input | 16 | Block length in bytes |
| blk_num | input | 16 | Number of blocks |
| host_wr_en | input | 1 | Host write strobe to the data register |
| host_wr_data | input | 16 | Host write data, byte 0 in bits 7:0 |
| host_rd_en | input | 1 | Host read strobe from the data register |
| host_rd_data | output | 16 | Data register read value, byte 0 in bits 7:0 |
| card_rx_valid | input | 1 | Card-to-buffer beat valid |
| card_rx_data | input | 16 | Card-to-buffer halfword |
| card_rx_ready | output | 1 | Buffer accepts a card beat |
| card_tx_valid | output | 1 | Buffer-to-card beat valid |
| card_tx_data | output | 16 | Buffer-to-card halfword |
| card_tx_ready | input | 1 | Card accepts a beat |
| rd_ready_small | output | 1 | At least 2 halfwords readable |
| rd_ready_burst | output | 1 | At least 16 halfwords readable |
| wr_ready_small | output | 1 | At least 2 halfword slots free |
| fifo_empty | output | 1 | Buffer empty |
| fifo_full | output | 1 | Buffer full |
| rx_active | output | 1 | Card-to-host transfer in progress |
| tx_active | output | 1 | Host-to-card transfer in progress |
| data_done | output | 1 | Transfer complete and buffer drained |
| rd_underflow | output | 1 | Sticky: read from an empty buffer |

## Verification
Directed runs cover the following:
- Filling to 32 halfwords and pushing beyond that, which separates a dropped write from a wrapped pointer.
- Draining past empty, which separates a held read value from a fresh one and exercises the underflow sticky bit.
- Odd and zero byte lengths, which show whether the halfword count rounds up and whether completion comes without traffic.
- A start pulse that coincides with host traffic, which shows that start takes priority.

A seeded random phase mixes random start pulses and random valid, ready and strobe patterns in both directions. This brings the occupancy across the 2- and 16-halfword thresholds from both sides. It also produces back-pressure on the card streams, which tells held data apart from advancing data.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } sdp_dir_e;

  typedef struct packed {
    logic rd_small;
    logic rd_burst;
    logic wr_small;
    logic empty;
    logic full;
  } sdp_flags_t;
endpackage

// File: rtl/sdp_fifo_mem.sv
module sdp_fifo_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] occ
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nx = wr_ptr + 1'b1;
      assign rd_nx = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nx = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push && !flush) store[wr_ptr] <= push_data;
  end

  assign head_data = store[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_nx;
      if (pop)  rd_ptr <= rd_nx;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // A full buffer stays full unless something leaves (guards the drop rule)
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH) && !pop && !flush) |=> (occ == CW'(DEPTH)));

  // An empty buffer stays empty unless something enters
  assert_empty_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !push && !flush) |=> (occ == '0));
endmodule

// File: rtl/sdp_flag_gen.sv
module sdp_flag_gen
  import sdp_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int SMALL_THR = 2,
  parameter int BURST_THR = 16,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] occ,
  output sdp_flags_t    flags
);
  localparam logic [CW-1:0] SMALL_C = CW'(SMALL_THR);
  localparam logic [CW-1:0] BURST_C = CW'(BURST_THR);
  localparam logic [CW-1:0] ROOM_C  = CW'(DEPTH - SMALL_THR);
  localparam logic [CW-1:0] FULL_C  = CW'(DEPTH);

  always_comb begin
    flags.rd_small = (occ >= SMALL_C);
    flags.rd_burst = (occ >= BURST_C);
    flags.wr_small = (occ <= ROOM_C);
    flags.empty    = (occ == '0);
    flags.full     = (occ == FULL_C);
  end
endmodule

// File: rtl/sdp_xfer_ctl.sv
module sdp_xfer_ctl
  import sdp_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int RW   = 2 * LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  sdp_dir_e         dir_in,
  input  logic [LEN_W-1:0] blk_bytes,
  input  logic [LEN_W-1:0] blk_num,
  input  logic             card_beat,
  output sdp_dir_e         dir_q,
  output logic             rem_zero,
  output logic             armed
);
  logic [RW-1:0] prod, hw_total, rem;

  assign prod     = RW'(blk_bytes) * RW'(blk_num);
  assign hw_total = (prod >> 1) + {{(RW-1){1'b0}}, prod[0]};
  assign rem_zero = (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      dir_q <= DIR_TX;
      armed <= 1'b0;
    end else if (start) begin
      rem   <= hw_total;
      dir_q <= dir_in;
      armed <= 1'b1;
    end else if (card_beat) begin
      rem   <= rem - 1'b1;
    end
  end

  // Card beats must stop once the count is exhausted: the count never wraps
  assert_rem_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_zero && !start) |=> rem_zero);
endmodule

// File: rtl/sd_data_port.sv
module sd_data_port
  import sdp_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int DW        = 16,
  parameter int LEN_W     = 16,
  parameter int SMALL_THR = 2,
  parameter int BURST_THR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_dir_rx,
  input  logic [LEN_W-1:0] blk_bytes,
  input  logic [LEN_W-1:0] blk_num,
  input  logic             host_wr_en,
  input  logic [DW-1:0]    host_wr_data,
  input  logic             host_rd_en,
  output logic [DW-1:0]    host_rd_data,
  input  logic             card_rx_valid,
  input  logic [DW-1:0]    card_rx_data,
  output logic             card_rx_ready,
  output logic             card_tx_valid,
  output logic [DW-1:0]    card_tx_data,
  input  logic             card_tx_ready,
  output logic             rd_ready_small,
  output logic             rd_ready_burst,
  output logic             wr_ready_small,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             rx_active,
  output logic             tx_active,
  output logic             data_done,
  output logic             rd_underflow
);
  localparam int CW = $clog2(DEPTH + 1);

  sdp_dir_e      dir_q;
  sdp_flags_t    flags;
  logic          rem_zero, armed, rx_mode;
  logic          host_wr_acc, host_rd_acc, rx_beat, tx_beat;
  logic          fifo_push, fifo_pop, card_beat;
  logic [DW-1:0] push_data, head;
  logic [CW-1:0] occ;

  assign rx_mode = (dir_q == DIR_RX);

  assign card_rx_ready = rx_mode && !rem_zero && !flags.full && !xfer_start;
  assign card_tx_valid = !rx_mode && !rem_zero && !flags.empty && !xfer_start;
  assign card_tx_data  = head;

  assign rx_beat     = card_rx_valid && card_rx_ready;
  assign tx_beat     = card_tx_valid && card_tx_ready;
  assign host_wr_acc = host_wr_en && !rx_mode && !flags.full && !xfer_start;
  assign host_rd_acc = host_rd_en && rx_mode && !flags.empty && !xfer_start;

  assign fifo_push = rx_mode ? rx_beat : host_wr_acc;
  assign fifo_pop  = rx_mode ? host_rd_acc : tx_beat;
  assign push_data = rx_mode ? card_rx_data : host_wr_data;
  assign card_beat = rx_mode ? rx_beat : tx_beat;

  sdp_xfer_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xfer_start),
    .dir_in    (sdp_dir_e'(xfer_dir_rx)),
    .blk_bytes (blk_bytes),
    .blk_num   (blk_num),
    .card_beat (card_beat),
    .dir_q     (dir_q),
    .rem_zero  (rem_zero),
    .armed     (armed)
  );

  sdp_fifo_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (xfer_start),
    .push      (fifo_push),
    .push_data (push_data),
    .pop       (fifo_pop),
    .head_data (head),
    .occ       (occ)
  );

  sdp_flag_gen #(.DEPTH(DEPTH), .SMALL_THR(SMALL_THR), .BURST_THR(BURST_THR)) u_flags (
    .occ   (occ),
    .flags (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rd_data <= '0;
      rd_underflow <= 1'b0;
    end else begin
      if (host_rd_acc) host_rd_data <= head;
      if (xfer_start)
        rd_underflow <= 1'b0;
      else if (host_rd_en && rx_mode && flags.empty)
        rd_underflow <= 1'b1;
    end
  end

  assign rd_ready_small = flags.rd_small;
  assign rd_ready_burst = flags.rd_burst;
  assign wr_ready_small = flags.wr_small;
  assign fifo_empty     = flags.empty;
  assign fifo_full      = flags.full;
  assign rx_active      = rx_mode && !rem_zero;
  assign tx_active      = !rx_mode && !rem_zero;
  assign data_done      = armed && rem_zero && flags.empty;

  // Reading an empty buffer holds the data register and raises the sticky bit
  assert_underflow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && rx_mode && fifo_empty && !xfer_start)
      |=> (rd_underflow && $stable(host_rd_data)));

  // Completion only with a drained buffer
  assert_done_drained_R12: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |-> fifo_empty);

  // Offered card data is held under back-pressure
  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && !card_tx_ready)
      |=> (xfer_start || (card_tx_valid && $stable(card_tx_data))));

  // The burst flag never shows without the small read flag
  assert_burst_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_burst |-> rd_ready_small);
endmodule

// File: tb/sd_data_port_tb_top.sv
`timescale 1ns/1ps
module sd_data_port_tb_top;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_start, xfer_dir_rx;
  logic [15:0] blk_bytes, blk_num;
  logic        host_wr_en, host_rd_en;
  logic [15:0] host_wr_data, host_rd_data;
  logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
  logic [15:0] card_rx_data, card_tx_data;
  logic        rd_ready_small, rd_ready_burst, wr_ready_small;
  logic        fifo_empty, fifo_full, rx_active, tx_active, data_done, rd_underflow;

  always #2.5 clk = ~clk;

  sd_data_port dut_i (.*);

  int unsigned n_cmp = 0, n_bad = 0;
  bit          fin = 0;

  // reference model state
  logic [15:0] mq[$];
  bit          m_rx, m_armed, m_uf;
  longint      m_rem;
  logic [15:0] m_rd;

  function automatic longint hw_of(int b, int n);
    longint t = longint'(b) * longint'(n);
    return (t + 1) / 2;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state();
    int sz = mq.size();
    chk("R4 rd_ready_small", 32'(rd_ready_small), 32'(sz >= 2));
    chk("R5 rd_ready_burst", 32'(rd_ready_burst), 32'(sz >= 16));
    chk("R6 wr_ready_small", 32'(wr_ready_small), 32'(DEPTH - sz >= 2));
    chk("R7 fifo_empty", 32'(fifo_empty), 32'(sz == 0));
    chk("R7 fifo_full", 32'(fifo_full), 32'(sz == DEPTH));
    chk("R10 rx_active", 32'(rx_active), 32'(m_rx && m_rem != 0));
    chk("R11 tx_active", 32'(tx_active), 32'(!m_rx && m_rem != 0));
    chk("R12 data_done", 32'(data_done), 32'(m_armed && m_rem == 0 && sz == 0));
    chk("R9 rd_underflow", 32'(rd_underflow), 32'(m_uf));
    chk("R13 host_rd_data", 32'(host_rd_data), 32'(m_rd));
  endtask

  // Drive one cycle's inputs at the falling edge, check, advance the model.
  task automatic cyc(bit st, bit dir, int b, int n, bit we, logic [15:0] wd,
                     bit re, bit rv, logic [15:0] rdat, bit tr);
    int sz;
    bit ps, pp, exp_rxr, exp_txv;
    logic [15:0] pv;
    xfer_start = st; xfer_dir_rx = dir; blk_bytes = 16'(b); blk_num = 16'(n);
    host_wr_en = we; host_wr_data = wd; host_rd_en = re;
    card_rx_valid = rv; card_rx_data = rdat; card_tx_ready = tr;
    #1;
    sz = mq.size();
    exp_rxr = !st && m_rx && m_rem != 0 && sz < DEPTH;
    exp_txv = !st && !m_rx && m_rem != 0 && sz > 0;
    chk("R10 card_rx_ready", 32'(card_rx_ready), 32'(exp_rxr));
    chk("R11 card_tx_valid", 32'(card_tx_valid), 32'(exp_txv));
    if (exp_txv) chk("R3 card_tx_data order", 32'(card_tx_data), 32'(mq[0]));
    ps = 0; pp = 0;
    if (st) begin
      mq.delete(); m_rx = dir; m_rem = hw_of(b, n); m_armed = 1; m_uf = 0;
    end else begin
      if (m_rx) begin
        ps = rv && exp_rxr;
        pp = re && sz > 0;
        if (re && sz == 0) m_uf = 1;
      end else begin
        ps = we && sz < DEPTH;
        pp = tr && exp_txv;
      end
      if (pp) begin
        pv = mq.pop_front();
        if (m_rx) m_rd = pv;
      end
      if (ps) mq.push_back(m_rx ? rdat : wd);
      if (m_rx ? ps : pp) m_rem--;
    end
    @(posedge clk);
    #1;
    check_state();
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 16'h0, 0, 0, 16'h0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    mq.delete(); m_rx = 0; m_armed = 0; m_uf = 0; m_rem = 0; m_rd = 16'h0;
    rst_n = 0;
    xfer_start = 0; xfer_dir_rx = 0; blk_bytes = 0; blk_num = 0;
    host_wr_en = 0; host_wr_data = 0; host_rd_en = 0;
    card_rx_valid = 0; card_rx_data = 0; card_tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 fifo_empty", 32'(fifo_empty), 32'd1);
    chk("R1 wr_ready_small", 32'(wr_ready_small), 32'd1);
    chk("R1 host_rd_data", 32'(host_rd_data), 32'd0);
    chk("R1 data_done", 32'(data_done), 32'd0);
    check_state();
    @(negedge clk);

    // R8/R7: fill past full in default host-to-card mode, no card pops (count zero)
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 0, 0, 1, 16'(16'h1000 + i), 0, 0, 16'h0, 1);
    chk("R8 full after overfill", 32'(fifo_full), 32'd1);

    // R2: start with simultaneous write discards it and flushes
    cyc(1, 0, 8, 2, 1, 16'hDEAD, 0, 0, 16'h0, 0);
    chk("R2 flushed on start", 32'(fifo_empty), 32'd1);

    // R3 byte placement: byte0=A1 in low bits
    cyc(0, 0, 0, 0, 1, 16'hB2A1, 0, 0, 16'h0, 0);
    #1;
    chk("R3 byte0 low bits", 32'(card_tx_data[7:0]), 32'h0A1);
    chk("R3 byte1 high bits", 32'(card_tx_data[15:8]), 32'h0B2);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0, 1, 16'(16'h2200 + i), 0, 0, 16'h0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 0, 16'h0, 0, 0, 16'h0, (i % 3) != 1);
    chk("R12 tx done", 32'(data_done), 32'd1);

    // R10/R5: card-to-host 64 bytes = 32 halfwords, one extra beat offered
    cyc(1, 1, 64, 1, 0, 16'h0, 0, 0, 16'h0, 0);
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 1, 0, 0, 1, 16'hFFFF, 0, 1, 16'(16'h3300 + i), 0);
    chk("R5 burst at full", 32'(rd_ready_burst), 32'd1);
    // R13/R9: drain past empty
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1, 0, 0, 0, 16'h0, 1, 0, 16'h0, 0);
    chk("R9 underflow sticky", 32'(rd_underflow), 32'd1);
    chk("R9 last value held", 32'(host_rd_data), 32'(16'h3300 + DEPTH - 1));

    // R2: odd length rounds up (5 bytes -> 3 halfwords)
    cyc(1, 1, 5, 1, 0, 16'h0, 0, 0, 16'h0, 0);
    chk("R2 underflow cleared", 32'(rd_underflow), 32'd0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 16'h0, 0, 1, 16'(16'h4400 + i), 0);
    chk("R2 odd length count", 32'(rd_ready_small), 32'd1);
    // R9: host read in host-to-card mode is ignored; zero length finishes at once (R12)
    cyc(1, 0, 0, 7, 0, 16'h0, 0, 0, 16'h0, 0);
    chk("R12 zero length done", 32'(data_done), 32'd1);
    cyc(0, 0, 0, 0, 0, 16'h0, 1, 0, 16'h0, 0);
    chk("R9 tx-mode read ignored", 32'(rd_underflow), 32'd0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      bit st = ($urandom_range(0, 63) == 0);
      cyc(st, 1'($urandom), int'($urandom_range(0, 80)), int'($urandom_range(0, 3)),
          1'($urandom), 16'($urandom), ($urandom_range(0, 2) != 0), 1'($urandom),
          16'($urandom), ($urandom_range(0, 3) != 0));
    end

    fin = 1;
    summary();
    $finish;
  end
endmodule